// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block holds the eight status flags of a serial port that runs in asynchronous or clocked synchronous mode. The flags cover the transmit side (data register empty, transmission finished) and the receive side (data register full, overrun, framing error, parity error). The register also holds the received multiprocessor bit and a software-written multiprocessor bit for transmit. The CPU reads the flags as one byte. It clears a flag by reading it as 1 and then writing 0 to its bit position. A DMA engine clears the data flags when it services the data registers.

Events from the receive shifter come in as single-cycle strobes. Each strobe carries its error conditions and its multiprocessor bit. The block decides in the same cycle whether the receive data register is loaded, and it drives that decision on a load strobe. The flags update on the next clock edge. An error flag that is set blocks any further reception. In clocked synchronous mode it also raises a transmit-inhibit output.

No port carries a data stream. Every pin is a plain level or a one-cycle pulse, so the block has no valid/ready handshake and applies no back-pressure. A completion that arrives while reception is blocked is dropped.

Top module: `serial_flag_reg`

## Requirements
- R1: The status byte holds, from bit 7 down to bit 0: TX-empty, RX-full, overrun, framing error, parity error, TX-done, received MP bit and transmit MP bit. Under reset it reads 8'h84.
- R2: Writing 0 to bit 7, 6, 5, 4 or 3 clears that flag only if an earlier read, with no write in between, saw the flag at 1. Writing 1 has no effect. A read and a write in the same cycle does not arm the clear. Every write disarms all flags.
- R3: Bit 0 takes write-data bit 0 on every write. Writes to bits 2 and 1 have no effect.
- R4: TX-empty is 1 in the cycle after any cycle with te low or with tx_xfer high. Otherwise an armed 0-write to bit 7, or dma_tdr_wr, clears it. A set in the same cycle beats a clear.
- R5: TX-done is set after a cycle in which te is low, or in which tx_last is high while TX-empty is 1. Otherwise the events that clear TX-empty clear it as well.
- R6: An accepted completion with no error, while RX-full is 0, raises rdr_load in that cycle and sets RX-full on the next edge. An armed 0-write to bit 6, or dma_rdr_rd, clears RX-full, and a set in the same cycle wins.
- R7: An accepted completion while RX-full is 1 sets the overrun flag. rdr_load stays low, and RX-full and the error flags keep their values.
- R8: An accepted completion while RX-full is 0 that carries a parity or framing error raises rdr_load. It sets the matching error flag and leaves RX-full at 0.
- R9: rx_inhibit is the OR of the overrun, framing and parity flags. While it is high, a completion is ignored: no rdr_load and no flag change. tx_inhibit is rx_inhibit AND sync_mode.
- R10: While re is low, a completion is ignored, and the receive flags and the MP bit keep their values.
- R11: The received MP bit takes rx_mp_bit from each completion that raises rdr_load, and keeps its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_rd | input | 1 | CPU read strobe of the status byte |
| reg_wr | input | 1 | CPU write strobe |
| reg_wdata | input | 8 | CPU write data |
| te | input | 1 | Transmit enable |
| re | input | 1 | Receive enable |
| sync_mode | input | 1 | 1 selects clocked synchronous mode |
| tx_xfer | input | 1 | Transmit data register moved into the shifter |
| tx_last | input | 1 | Last bit of a character shifted out |
| dma_tdr_wr | input | 1 | DMA wrote the transmit data register |
| dma_rdr_rd | input | 1 | DMA read the receive data register |
| rx_done | input | 1 | Receive shifter completed a frame |
| rx_par_err | input | 1 | Parity mismatch on the completed frame |
| rx_frm_err | input | 1 | First stop bit sampled as 0 |
| rx_mp_bit | input | 1 | Multiprocessor bit of the completed frame |
| status | output | 8 | Flag byte, layout as in R1 |
| rdr_load | output | 1 | Load strobe for the receive data register |
| rx_inhibit | output | 1 | Reception blocked by an error flag |
| tx_inhibit | output | 1 | Transmission blocked (synchronous mode) |

## Verification
The assertions assume that each event input is a pulse that the shifters raise only when it is meaningful, and that rx_par_err, rx_frm_err and rx_mp_bit are valid in any cycle with rx_done high. The stimulus drives each pulse for exactly one cycle and sets the error and MP bits together with rx_done. Some cycles deliberately combine a CPU clear with a hardware set, and some combine a read with a write.

// File: rtl/sflag_pkg.sv
package sflag_pkg;
  localparam int REG_W  = 8;
  localparam int N_CLR  = 5;   // flags cleared by the read-1/write-0 sequence
  localparam int N_RXF  = 4;   // rx-side clearable flags
  localparam int B_TDRE = 7;
  localparam int B_RDRF = 6;
  localparam int B_ORER = 5;
  localparam int B_FER  = 4;
  localparam int B_PER  = 3;
  localparam int B_TEND = 2;
  localparam int B_MPB  = 1;
  localparam int B_MPBT = 0;
  localparam logic [REG_W-1:0] RST_VAL =
    (REG_W'(1) << B_TDRE) | (REG_W'(1) << B_TEND);
endpackage

// File: rtl/sflag_arm.sv
// Per-flag "seen as 1" tracker; produces a one-cycle clear request.
module sflag_arm #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd,
  input  logic         wr,
  input  logic [N-1:0] wbits,
  input  logic [N-1:0] flag_q,
  input  logic [N-1:0] flag_d,
  output logic [N-1:0] clr
);
  logic [N-1:0] arm_q;

  assign clr = {N{wr}} & ~wbits & arm_q;

  for (genvar i = 0; i < N; i++) begin : g_arm
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          arm_q[i] <= 1'b0;
      else if (wr)         arm_q[i] <= 1'b0;
      else if (!flag_d[i]) arm_q[i] <= 1'b0;
      else if (rd && flag_q[i]) arm_q[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/sflag_tx.sv
module sflag_tx (
  input  logic clk,
  input  logic rst_n,
  input  logic te,
  input  logic tx_xfer,
  input  logic tx_last,
  input  logic dma_wr,
  input  logic cpu_clr,
  output logic tdre_q,
  output logic tend_q,
  output logic tdre_d
);
  logic tend_d;
  logic drop;

  always_comb begin
    drop   = cpu_clr | dma_wr;
    tdre_d = tdre_q;
    tend_d = tend_q;
    if (drop) begin
      tdre_d = 1'b0;
      tend_d = 1'b0;
    end
    if (!te || tx_xfer)          tdre_d = 1'b1;
    if (!te || (tx_last && tdre_q)) tend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdre_q <= 1'b1;
      tend_q <= 1'b1;
    end else begin
      tdre_q <= tdre_d;
      tend_q <= tend_d;
    end
  end
endmodule

// File: rtl/sflag_rx.sv
// Flag order in vectors: [3]=full, [2]=overrun, [1]=framing, [0]=parity.
module sflag_rx #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          re,
  input  logic          rx_done,
  input  logic          par_err,
  input  logic          frm_err,
  input  logic          mp_bit,
  input  logic          dma_rd,
  input  logic [NF-1:0] cpu_clr,
  output logic [NF-1:0] flags_q,
  output logic [NF-1:0] flags_d,
  output logic          mpb_q,
  output logic          load,
  output logic          inhibit
);
  logic accept, ovr, err, good;

  assign inhibit = flags_q[2] | flags_q[1] | flags_q[0];
  assign accept  = rx_done & re & ~inhibit;
  assign ovr     = accept & flags_q[3];
  assign load    = accept & ~flags_q[3];
  assign err     = load & (par_err | frm_err);
  assign good    = load & ~par_err & ~frm_err;

  always_comb begin
    flags_d = flags_q;
    if (cpu_clr[3] || dma_rd) flags_d[3] = 1'b0;
    for (int k = 0; k < NF - 1; k++)
      if (cpu_clr[k]) flags_d[k] = 1'b0;
    if (good)            flags_d[3] = 1'b1;
    if (ovr)             flags_d[2] = 1'b1;
    if (err && frm_err)  flags_d[1] = 1'b1;
    if (err && par_err)  flags_d[0] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      mpb_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      if (load) mpb_q <= mp_bit;
    end
  end
endmodule

// File: rtl/serial_flag_reg.sv
module serial_flag_reg
  import sflag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             te,
  input  logic             re,
  input  logic             sync_mode,
  input  logic             tx_xfer,
  input  logic             tx_last,
  input  logic             dma_tdr_wr,
  input  logic             dma_rdr_rd,
  input  logic             rx_done,
  input  logic             rx_par_err,
  input  logic             rx_frm_err,
  input  logic             rx_mp_bit,
  output logic [REG_W-1:0] status,
  output logic             rdr_load,
  output logic             rx_inhibit,
  output logic             tx_inhibit
);
  logic [N_CLR-1:0] clr_q, clr_d, clr_req;
  logic [N_RXF-1:0] rxf_q, rxf_d;
  logic tdre_q, tdre_d, tend_q, mpb_q, mpbt_q;

  sflag_tx u_tx (
    .clk(clk), .rst_n(rst_n), .te(te), .tx_xfer(tx_xfer), .tx_last(tx_last),
    .dma_wr(dma_tdr_wr), .cpu_clr(clr_req[N_CLR-1]),
    .tdre_q(tdre_q), .tend_q(tend_q), .tdre_d(tdre_d)
  );

  sflag_rx #(.NF(N_RXF)) u_rx (
    .clk(clk), .rst_n(rst_n), .re(re), .rx_done(rx_done),
    .par_err(rx_par_err), .frm_err(rx_frm_err), .mp_bit(rx_mp_bit),
    .dma_rd(dma_rdr_rd), .cpu_clr(clr_req[N_RXF-1:0]),
    .flags_q(rxf_q), .flags_d(rxf_d), .mpb_q(mpb_q),
    .load(rdr_load), .inhibit(rx_inhibit)
  );

  assign clr_q = {tdre_q, rxf_q};
  assign clr_d = {tdre_d, rxf_d};

  sflag_arm #(.N(N_CLR)) u_arm (
    .clk(clk), .rst_n(rst_n), .rd(reg_rd), .wr(reg_wr),
    .wbits(reg_wdata[B_TDRE -: N_CLR]), .flag_q(clr_q), .flag_d(clr_d),
    .clr(clr_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mpbt_q <= RST_VAL[B_MPBT];
    else if (reg_wr) mpbt_q <= reg_wdata[B_MPBT];
  end

  always_comb begin
    status         = '0;
    status[B_TDRE] = tdre_q;
    status[B_RDRF] = rxf_q[3];
    status[B_ORER] = rxf_q[2];
    status[B_FER]  = rxf_q[1];
    status[B_PER]  = rxf_q[0];
    status[B_TEND] = tend_q;
    status[B_MPB]  = mpb_q;
    status[B_MPBT] = mpbt_q;
  end

  assign tx_inhibit = sync_mode & rx_inhibit;
endmodule

// File: rtl/serial_flag_reg_chk.sv
module serial_flag_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic       te,
  input logic       re,
  input logic       tx_last,
  input logic       dma_rdr_rd,
  input logic       rx_done,
  input logic       rx_par_err,
  input logic       rx_frm_err,
  input logic [7:0] status,
  input logic       rdr_load,
  input logic       rx_inhibit,
  input logic       tx_inhibit
);
  assert_mpbt_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> status[0] == $past(reg_wdata[0]));
  assert_te_off_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !te |=> status[7]);
  assert_tend_on_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_last && status[7]) |=> status[2]);
  assert_full_only_by_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[6]) |-> $past(rdr_load));
  assert_no_load_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && re && !rx_inhibit && status[6]) |-> !rdr_load);
  assert_overrun_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && re && !rx_inhibit && status[6]) |=> status[5]);
  assert_err_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && re && !rx_inhibit && !status[6] && (rx_par_err || rx_frm_err))
      |-> rdr_load);
  assert_err_keeps_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rdr_load && (rx_par_err || rx_frm_err) && !dma_rdr_rd) |=> !status[6]);
  assert_inhibit_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_inhibit |-> !rdr_load);
  assert_tx_inhibit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_inhibit |-> rx_inhibit);
  assert_re_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !re |-> !rdr_load);
endmodule

bind serial_flag_reg serial_flag_reg_chk chk_i (.*);

// File: tb/serial_flag_reg_test.sv
`timescale 1ns/1ps
module serial_flag_reg_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_rd = 0, reg_wr = 0;
  logic [7:0] reg_wdata = 8'h00;
  logic te = 0, re = 0, sync_mode = 0;
  logic tx_xfer = 0, tx_last = 0, dma_tdr_wr = 0, dma_rdr_rd = 0;
  logic rx_done = 0, rx_par_err = 0, rx_frm_err = 0, rx_mp_bit = 0;
  logic [7:0] status;
  logic rdr_load, rx_inhibit, tx_inhibit;

  serial_flag_reg uut (.*);

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  // behavioural reference state
  bit m_tdre = 1, m_rdrf = 0, m_orer = 0, m_fer = 0, m_per = 0;
  bit m_tend = 1, m_mpb = 0, m_mpbt = 0;
  bit a_tdre = 0, a_rdrf = 0, a_orer = 0, a_fer = 0, a_per = 0;

  function automatic bit [7:0] model_byte();
    return {m_tdre, m_rdrf, m_orer, m_fer, m_per, m_tend, m_mpb, m_mpbt};
  endfunction

  task automatic model_step();
    bit blocked, take, c7, c6, c5, c4, c3;
    bit n_tdre, n_rdrf, n_orer, n_fer, n_per, n_tend;
    if (!rst_n) begin
      {m_tdre, m_rdrf, m_orer, m_fer, m_per, m_tend, m_mpb, m_mpbt} = 8'h84;
      {a_tdre, a_rdrf, a_orer, a_fer, a_per} = 5'b0;
      return;
    end
    blocked = m_orer || m_fer || m_per;
    take = rx_done && re && !blocked;
    c7 = reg_wr && !reg_wdata[7] && a_tdre;
    c6 = reg_wr && !reg_wdata[6] && a_rdrf;
    c5 = reg_wr && !reg_wdata[5] && a_orer;
    c4 = reg_wr && !reg_wdata[4] && a_fer;
    c3 = reg_wr && !reg_wdata[3] && a_per;
    n_tdre = m_tdre; n_tend = m_tend; n_rdrf = m_rdrf;
    n_orer = m_orer; n_fer = m_fer; n_per = m_per;
    if (c7 || dma_tdr_wr) begin n_tdre = 0; n_tend = 0; end
    if (!te || tx_xfer) n_tdre = 1;
    if (!te || (tx_last && m_tdre)) n_tend = 1;
    if (c6 || dma_rdr_rd) n_rdrf = 0;
    if (c5) n_orer = 0;
    if (c4) n_fer = 0;
    if (c3) n_per = 0;
    if (take) begin
      if (m_rdrf) n_orer = 1;
      else begin
        if (rx_par_err) n_per = 1;
        if (rx_frm_err) n_fer = 1;
        if (!rx_par_err && !rx_frm_err) n_rdrf = 1;
        m_mpb = rx_mp_bit;
      end
    end
    if (reg_wr) begin
      m_mpbt = reg_wdata[0];
      {a_tdre, a_rdrf, a_orer, a_fer, a_per} = 5'b0;
    end else begin
      a_tdre = n_tdre && (a_tdre || (reg_rd && m_tdre));
      a_rdrf = n_rdrf && (a_rdrf || (reg_rd && m_rdrf));
      a_orer = n_orer && (a_orer || (reg_rd && m_orer));
      a_fer  = n_fer  && (a_fer  || (reg_rd && m_fer));
      a_per  = n_per  && (a_per  || (reg_rd && m_per));
    end
    m_tdre = n_tdre; m_tend = n_tend; m_rdrf = n_rdrf;
    m_orer = n_orer; m_fer = n_fer; m_per = n_per;
  endtask

  task automatic tick(input string req);
    bit blk, e_load;
    #1;
    blk = m_orer || m_fer || m_per;
    e_load = rst_n && rx_done && re && !blk && !m_rdrf;
    n_cmp++;
    if (status !== model_byte() || rdr_load !== e_load ||
        rx_inhibit !== blk || tx_inhibit !== (blk && sync_mode)) begin
      n_bad++;
      $display("FAIL %s: status=%h load=%b rxinh=%b txinh=%b expected status=%h load=%b rxinh=%b txinh=%b",
               req, status, rdr_load, rx_inhibit, tx_inhibit,
               model_byte(), e_load, blk, blk && sync_mode);
    end
    model_step();
    @(negedge clk);
    reg_rd = 0; reg_wr = 0; reg_wdata = 8'h00;
    tx_xfer = 0; tx_last = 0; dma_tdr_wr = 0; dma_rdr_rd = 0;
    rx_done = 0; rx_par_err = 0; rx_frm_err = 0; rx_mp_bit = 0;
  endtask

  task automatic cpu_rd(input string req);
    reg_rd = 1; tick(req);
  endtask
  task automatic cpu_wr(input logic [7:0] d, input string req);
    reg_wr = 1; reg_wdata = d; tick(req);
  endtask
  task automatic rx(input bit par, input bit frm, input bit mp, input string req);
    rx_done = 1; rx_par_err = par; rx_frm_err = frm; rx_mp_bit = mp; tick(req);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 50000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    tick("R1");                       // reset byte 84
    rst_n = 1;
    tick("R1");
    te = 1; re = 1;
    // R2: unarmed write, write-1, disarm by write
    cpu_wr(8'h00, "R2");
    cpu_rd("R2");
    cpu_wr(8'hFF, "R2");
    cpu_wr(8'h7F, "R2");
    // R4: armed clear of TX-empty also clears TX-done (R5), MPBT=1 (R3)
    cpu_rd("R4");
    cpu_wr(8'h7F, "R4");
    // R3: writes to bits 2,1 ignored; MPBT toggles
    cpu_wr(8'h06, "R3");
    cpu_wr(8'h01, "R3");
    // R4: transfer sets; set wins over armed clear; DMA clears
    tx_xfer = 1; tick("R4");
    cpu_rd("R4");
    reg_wr = 1; reg_wdata = 8'h7F; tx_xfer = 1; tick("R4");
    dma_tdr_wr = 1; tick("R4");
    // R5
    tx_last = 1; tick("R5");          // TX-empty 0: no set
    tx_xfer = 1; tick("R5");
    tx_last = 1; tick("R5");
    tick("R5");
    dma_tdr_wr = 1; tick("R5");
    te = 0; tick("R5");
    te = 1; tick("R5");
    // R6 good receive, R11 mp bit
    rx(0, 0, 1, "R6");
    tick("R11");
    // R7 overrun, data lost, mp unchanged
    rx(0, 0, 0, "R7");
    tick("R7");
    // R9 inhibit
    rx(1, 1, 1, "R9");
    sync_mode = 1; tick("R9");
    cpu_rd("R9");
    cpu_wr(8'hDF, "R9");
    sync_mode = 0; tick("R9");
    dma_rdr_rd = 1; tick("R6");
    // R8 parity then framing
    rx(1, 0, 1, "R8");
    rx(0, 0, 0, "R8");
    cpu_rd("R8");
    cpu_wr(8'hF7, "R8");
    rx(0, 1, 0, "R8");
    rx(0, 0, 1, "R8");
    cpu_rd("R8");
    cpu_wr(8'hEF, "R8");
    // R10 receive disabled
    re = 0; rx(0, 0, 1, "R10");
    tick("R10");
    re = 1; tick("R10");
    // R6 set-wins and read+write same cycle (R2)
    rx(0, 0, 0, "R6");
    reg_rd = 1; reg_wr = 1; reg_wdata = 8'hBF; tick("R2");
    cpu_wr(8'hBF, "R2");
    cpu_rd("R6");
    reg_wr = 1; reg_wdata = 8'hBF; tick("R6");
    rx(0, 0, 1, "R11");
    cpu_rd("R6");
    reg_wr = 1; reg_wdata = 8'hBF; dma_rdr_rd = 1; tick("R6");
    tick("R6");
    finish_run();
  end
endmodule